// File: doc/BRIEF.md
# Serial Flip-Flop Chain Upset Monitor

This block checks a long serial chain of flip-flops for single-event upsets. After a start pulse it drives an alternating stimulus into the chain head, one bit per shift, beginning with 0. The chain tail returns to the block. The chain itself sits outside the block. It can be an on-die test chain or an external device under test. Because the stimulus is fixed and the chain length is a parameter, the block knows which bit must leave the tail on every shift. It compares that bit with the bit that actually arrives.

Each disagreement is counted once and sorted by the direction of the flip. A one that arrives as zero goes to one counter, and a zero that arrives as one goes to the other. A third counter keeps the total. The counters are outputs that can be read at any time, including while the chain is shifting. They saturate at full scale, and a synchronous clear sets all three to zero.

The serial path has no valid/ready handshake, because the chain cannot hold data back. The shift enable input is the only flow control. While it is low, nothing moves: the stimulus holds, no bit is compared and no counter changes. The chain must be clocked under the same enable, so that it shifts exactly on the cycles the monitor counts as shifts.

Top module: `upset_chain_monitor`

## Requirements
- R1: After a start pulse, the stimulus on `chain_sdo` is 0 for the first shift and inverts after every shift, giving 0,1,0,1,... in shift order.
- R2: A shift happens only on a cycle with `shift_en` high, after a start and with no start on that cycle. On any other cycle `chain_sdo` and all counters hold their values, unless a clear or a start acts.
- R3: On a counted shift, the expected tail bit is the stimulus driven CHAIN_LEN shifts earlier. If 1 is expected and `chain_sdi` is 0, `cnt_hi_lo` increments. If 0 is expected and `chain_sdi` is 1, `cnt_lo_hi` increments.
- R4: One flipped bit inside the chain adds exactly one count when it leaves the tail. The following shifts add nothing more.
- R5: For the first CHAIN_LEN shifts after a start, no comparison is made. Whatever the chain held before does not count.
- R6: `cnt_total` increments on every counted mismatch of either direction. Below saturation it equals `cnt_hi_lo + cnt_lo_hi`.
- R7: Each counter stops at 2^CNT_W-1 and never wraps.
- R8: A `clear` pulse sets all three counters to 0 on the next edge. Clear wins over a simultaneous increment, and counting continues afterwards.
- R9: After reset the block is idle, `chain_sdo` is 0 and all counters are 0.
- R10: A start while the block is running restarts the stimulus at 0 and opens a new fill window of CHAIN_LEN uncounted shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins or restarts the test run |
| clear | input | 1 | Synchronous clear of all counters |
| shift_en | input | 1 | Shift enable; the chain shifts on the same cycles |
| chain_sdo | output | 1 | Stimulus bit to the chain head |
| chain_sdi | input | 1 | Bit returned from the chain tail |
| cnt_hi_lo | output | CNT_W | One-to-zero upset count |
| cnt_lo_hi | output | CNT_W | Zero-to-one upset count |
| cnt_total | output | CNT_W | Total upset count |

## Verification
A stimulus phase that is wrong by one shift makes every tail bit disagree with its prediction. The counters then climb on every counted shift, starting at shift CHAIN_LEN+1 after start. A fill window that is wrong in length shows up sooner: if it ends early, stale chain contents are counted within the first CHAIN_LEN shifts; if it ends late, an injected flip that exits just after the window is missed. A wrong direction decode or wrong saturation shows on the counters at the edge where the flipped bit leaves the tail. The bench checks `chain_sdo` and all three counters against its model after every clock.

// File: rtl/ucm_pkg.sv
package ucm_pkg;
  typedef struct packed {
    logic hi_lo;
    logic lo_hi;
  } upset_t;

  localparam int unsigned NUM_CNT = 3;
  localparam int unsigned IDX_HI_LO = 0;
  localparam int unsigned IDX_LO_HI = 1;
  localparam int unsigned IDX_TOTAL = 2;
endpackage

// File: rtl/ucm_stimulus.sv
module ucm_stimulus #(
  parameter int unsigned CHAIN_LEN = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic shift_en,
  output logic stim_bit,
  output logic shift_fire,
  output logic armed,
  output logic exp_bit
);
  localparam int unsigned FILL_W = $clog2(CHAIN_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_END = FILL_W'(CHAIN_LEN);
  localparam logic LEN_ODD = CHAIN_LEN[0];

  logic              running;
  logic [FILL_W-1:0] fill_q;

  assign shift_fire = running && shift_en && !start;
  assign armed      = (fill_q == FILL_END);
  // Alternating stimulus delayed by CHAIN_LEN shifts differs only by length parity.
  assign exp_bit    = stim_bit ^ LEN_ODD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      stim_bit <= 1'b0;
      fill_q   <= '0;
    end else if (start) begin
      running  <= 1'b1;
      stim_bit <= 1'b0;
      fill_q   <= '0;
    end else if (shift_fire) begin
      stim_bit <= ~stim_bit;
      if (fill_q != FILL_END) fill_q <= fill_q + 1'b1;
    end
  end

  AST_STIM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> (stim_bit != $past(stim_bit))); // R1
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (stim_bit == 1'b0 && !armed)); // R10
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_fire && !start) |=> $stable(stim_bit)); // R2
endmodule

// File: rtl/ucm_classify.sv
module ucm_classify
  import ucm_pkg::*;
(
  input  logic   shift_fire,
  input  logic   armed,
  input  logic   exp_bit,
  input  logic   chain_sdi,
  output upset_t upset
);
  logic judge;
  assign judge = shift_fire && armed;

  always_comb begin
    upset       = '0;
    upset.hi_lo = judge &&  exp_bit && !chain_sdi;
    upset.lo_hi = judge && !exp_bit &&  chain_sdi;
  end
endmodule

// File: rtl/ucm_sat_counter.sv
module ucm_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] q
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr)              q <= '0;
    else if (inc && q != FULL) q <= q + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q == FULL && !clr) |=> (q == FULL)); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (q >= $past(q))); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(q)); // R2
endmodule

// File: rtl/upset_chain_monitor.sv
module upset_chain_monitor
  import ucm_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 15000,
  parameter int unsigned CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clear,
  input  logic             shift_en,
  output logic             chain_sdo,
  input  logic             chain_sdi,
  output logic [CNT_W-1:0] cnt_hi_lo,
  output logic [CNT_W-1:0] cnt_lo_hi,
  output logic [CNT_W-1:0] cnt_total
);
  logic   shift_fire;
  logic   armed;
  logic   exp_bit;
  upset_t upset;

  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  ucm_stimulus #(.CHAIN_LEN(CHAIN_LEN)) u_stim (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .shift_en   (shift_en),
    .stim_bit   (chain_sdo),
    .shift_fire (shift_fire),
    .armed      (armed),
    .exp_bit    (exp_bit)
  );

  ucm_classify u_cls (
    .shift_fire (shift_fire),
    .armed      (armed),
    .exp_bit    (exp_bit),
    .chain_sdi  (chain_sdi),
    .upset      (upset)
  );

  assign inc_vec[IDX_HI_LO] = upset.hi_lo;
  assign inc_vec[IDX_LO_HI] = upset.lo_hi;
  assign inc_vec[IDX_TOTAL] = upset.hi_lo | upset.lo_hi;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    ucm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clear),
      .inc   (inc_vec[g]),
      .q     (cnt_arr[g])
    );
  end

  assign cnt_hi_lo = cnt_arr[IDX_HI_LO];
  assign cnt_lo_hi = cnt_arr[IDX_LO_HI];
  assign cnt_total = cnt_arr[IDX_TOTAL];

  AST_FILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !clear) |=> $stable(cnt_total)); // R5
  AST_TOTAL_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_total >= cnt_hi_lo) && (cnt_total >= cnt_lo_hi)); // R6
  AST_ONE_PER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt_total - $past(cnt_total) <= CNT_W'(1))); // R4
endmodule

// File: tb/upset_chain_monitor_tb.sv
module upset_chain_monitor_tb;
  localparam int unsigned N     = 8;
  localparam int unsigned CW    = 4;
  localparam int          MAXC  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic clear = 1'b0;
  logic shift_en = 1'b0;
  logic chain_sdo;
  logic chain_sdi;
  logic [CW-1:0] cnt_hi_lo, cnt_lo_hi, cnt_total;

  logic chain [N];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  bit m_run = 0;
  bit m_stim = 0;
  bit sent[$];
  int m_hl = 0, m_lh = 0, m_tot = 0;

  always #2 clk = ~clk;

  upset_chain_monitor #(.CHAIN_LEN(N), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
    .shift_en(shift_en), .chain_sdo(chain_sdo), .chain_sdi(chain_sdi),
    .cnt_hi_lo(cnt_hi_lo), .cnt_lo_hi(cnt_lo_hi), .cnt_total(cnt_total)
  );

  assign chain_sdi = chain[N-1];

  initial for (int i = 0; i < N; i++) chain[i] = 1'b1;

  // chain under test and behavioural reference
  always @(posedge clk) begin
    bit sh;
    bit e;
    sh = rst_n && m_run && shift_en && !start;
    if (sh) begin
      for (int i = N - 1; i > 0; i--) chain[i] <= chain[i-1];
      chain[0] <= chain_sdo;
    end
    if (!rst_n) begin
      m_run = 0; m_stim = 0; sent.delete(); m_hl = 0; m_lh = 0; m_tot = 0;
    end else begin
      if (sh && sent.size() == N) begin
        e = sent.pop_front();
        if (e && !chain_sdi) begin
          if (m_hl < MAXC) m_hl++;
          if (m_tot < MAXC) m_tot++;
        end
        if (!e && chain_sdi) begin
          if (m_lh < MAXC) m_lh++;
          if (m_tot < MAXC) m_tot++;
        end
      end
      if (sh) begin
        sent.push_back(m_stim);
        m_stim = ~m_stim;
      end
      if (clear) begin m_hl = 0; m_lh = 0; m_tot = 0; end
      if (start) begin m_run = 1; m_stim = 0; sent.delete(); end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(chain_sdo == m_stim, "R1 stimulus", chain_sdo, m_stim);
      chk(cnt_hi_lo == m_hl, "R3 hi_lo", cnt_hi_lo, m_hl);
      chk(cnt_lo_hi == m_lh, "R3 lo_hi", cnt_lo_hi, m_lh);
      chk(cnt_total == m_tot, "R6 total", cnt_total, m_tot);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; cycles(1); start = 1'b0;
  endtask

  task automatic pulse_clear();
    clear = 1'b1; cycles(1); clear = 1'b0;
  endtask

  // flip one chain bit currently holding the given value
  task automatic flip_one(input bit want);
    for (int i = N - 1; i >= 0; i--) begin
      if (chain[i] == want) begin
        chain[i] = ~want;
        return;
      end
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic sdo_hold;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R9 reset state
    chk(chain_sdo == 1'b0, "R9 sdo after reset", chain_sdo, 0);
    chk(cnt_total == 0 && cnt_hi_lo == 0 && cnt_lo_hi == 0, "R9 counters after reset", cnt_total, 0);
    // R2 idle: shift_en high but no start yet
    shift_en = 1'b1;
    cycles(4);
    chk(chain_sdo == 1'b0, "R2 no shift before start", chain_sdo, 0);

    // R5 chain preloaded with ones must not count during fill
    pulse_start();
    cycles(2 * N + 4);
    chk(cnt_total == 0, "R5 stale contents ignored", cnt_total, 0);

    // R2 pause holds everything
    shift_en = 1'b0;
    sdo_hold = chain_sdo;
    cycles(5);
    chk(chain_sdo == sdo_hold, "R2 sdo stable in pause", chain_sdo, sdo_hold);
    chk(cnt_total == 0, "R2 counters stable in pause", cnt_total, 0);
    shift_en = 1'b1;

    // R3/R4 one-to-zero flip counted once
    flip_one(1'b1);
    cycles(N + 2);
    chk(cnt_hi_lo == 1, "R3 one-to-zero", cnt_hi_lo, 1);
    chk(cnt_total == 1, "R6 total after one", cnt_total, 1);
    cycles(N + 3);
    chk(cnt_total == 1, "R4 single count then match", cnt_total, 1);

    // R3 zero-to-one flip
    flip_one(1'b0);
    cycles(N + 2);
    chk(cnt_lo_hi == 1, "R3 zero-to-one", cnt_lo_hi, 1);
    chk(cnt_total == 2, "R6 total sum", cnt_total, 2);

    // R4 two flips in the same pass count twice
    flip_one(1'b1);
    flip_one(1'b1);
    cycles(N + 2);
    chk(cnt_hi_lo == 3, "R4 two flips two counts", cnt_hi_lo, 3);

    // R8 clear while shifting
    pulse_clear();
    chk(cnt_total == 0 && cnt_hi_lo == 0 && cnt_lo_hi == 0, "R8 clear", cnt_total, 0);
    flip_one(1'b0);
    cycles(N + 2);
    chk(cnt_lo_hi == 1, "R8 counting resumes", cnt_lo_hi, 1);

    // R7 saturation
    for (int k = 0; k < MAXC + 5; k++) begin
      flip_one(1'b1);
      cycles(N + 1);
    end
    chk(cnt_hi_lo == MAXC, "R7 hi_lo saturates", cnt_hi_lo, MAXC);
    chk(cnt_total == MAXC, "R7 total saturates", cnt_total, MAXC);
    flip_one(1'b0);
    cycles(N + 2);
    chk(cnt_lo_hi == 2, "R7 other counter still counts", cnt_lo_hi, 2);
    chk(cnt_total == MAXC, "R7 total no wrap", cnt_total, MAXC);

    // R10 restart re-arms fill window
    pulse_clear();
    pulse_start();
    flip_one(chain[N-1]);
    cycles(N + 4);
    chk(cnt_total == 0, "R10 restart fill suppresses", cnt_total, 0);
    flip_one(1'b1);
    cycles(N + 2);
    chk(cnt_hi_lo == 1, "R10 counting after refill", cnt_hi_lo, 1);

    cycles(2);
    finish_run();
  end
endmodule